// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block is a management master for a clause-22 MDIO port. Software loads one 32-bit command word through a simple write strobe. The word is already laid out bit for bit as the serial management frame. The engine first sends a preamble of ones. It then shifts the word out on MDIO, most significant bit first, timed by an MDC clock that it divides down from the host clock.

For a read, the engine stops driving MDIO from the second turnaround bit onward. It samples the sixteen data bits that the PHY returns and places them in bits 15:0 of the command word. Software can read the result back on `cmd_o`.

An idle flag tells software when the port can accept a new command and when the last one has finished. The port runs only while its enable input is high. Dropping the enable in the middle of a frame abandons that frame.

Top module: `mdio_master`

## Requirements
- R1: After reset, `idle_o` is 1, `mdc_o` is 0, `mdio_oe_o` is 0 and `cmd_o` is zero.
- R2: A write strobe that arrives while the port is idle and enabled is accepted. `idle_o` reads 0 from the next cycle. It returns to 1 exactly (PRE_LEN+32)*CLK_DIV host cycles after the accepting edge.
- R3: While a frame runs, MDC has a period of CLK_DIV host cycles. Each period starts with CLK_DIV/2 cycles low, followed by CLK_DIV/2 cycles high. MDC stays low whenever the port is idle.
- R4: A frame starts with PRE_LEN bit periods in which MDIO is driven to 1. The 32 command bits follow in order from bit 31 down to bit 0. MDIO changes only at the start of a bit period, that is, on the falling MDC edge, so it is stable at the rising edge.
- R5: When bits 29:28 of the command are not 2'b10, the frame is a write. MDIO is driven for all PRE_LEN+32 bit periods, and `cmd_o` keeps the written word after completion.
- R6: When bits 29:28 of the command equal 2'b10, the frame is a read. The master drives only through frame bit 17, then releases MDIO from bit 16 to the end of the frame. It samples frame bits 15..0 on the rising MDC edges. After completion, `cmd_o[15:0]` holds the sampled data and `cmd_o[31:16]` is unchanged.
- R7: A read from an address where no PHY answers returns 16'hFFFF in `cmd_o[15:0]`, because the released line reads high.
- R8: A write strobe that arrives while a frame is running is ignored. `cmd_o`, the serial bits and the frame length all stay those of the running frame.
- R9: A write strobe that arrives while `port_en_i` is 0 is ignored. If `port_en_i` drops during a frame, then one cycle later `idle_o` is 1, `mdc_o` is 0 and `mdio_oe_o` is 0, and `cmd_o` is unchanged.
- R10: In the cycle after an accepted write, `cmd_o` equals the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_en_i | input | 1 | Management port enable |
| cmd_we_i | input | 1 | Command word write strobe |
| cmd_wdata_i | input | 32 | Command word to load |
| cmd_o | output | 32 | Command word readback, read data in 15:0 after a read |
| idle_o | output | 1 | Port idle flag |
| mdc_o | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| mdio_o | output | 1 | MDIO drive value |
| mdio_oe_o | output | 1 | MDIO drive enable |

## Verification
The hardest situation to reach from the ports is a read in which the line is released and the PHY must drive each data bit in the low phase of MDC. The bench models the PHY in step with MDC. It counts rising MDC edges from the start of the frame, and on each falling edge it places the next data bit from the second turnaround slot onward. A PHY that is switched off makes the line read high through the pull-up. Mid-frame events are reached by timing strobes against the measured frame length: a second write during a frame, and the enable dropping during a read. Each of these events is followed by an observation of `cmd_o`, the idle flag and the pins.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned FRAME_W = 32;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned FIDX_W  = $clog2(FRAME_W);
  localparam int unsigned OP_HI   = 29;
  localparam int unsigned OP_LO   = 28;
  localparam logic [1:0]  OP_RD   = 2'b10;
  // frame index counts from 0 at word bit 31
  localparam int unsigned REL_IDX = FRAME_W - 1 - DATA_W;  // word bit 16
  localparam int unsigned DAT_IDX = FRAME_W - DATA_W;      // word bit 15

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_PRE,
    PH_FRM
  } phase_e;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int unsigned CLK_DIV = 48
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic rise_o,
  output logic tick_o,
  output logic mdc_o
);
  localparam int unsigned CW   = $clog2(CLK_DIV);
  localparam int unsigned HALF = CLK_DIV / 2;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;

  assign rise_o = run_i && (cnt_q == CW'(HALF - 1));
  assign tick_o = run_i && (cnt_q == CW'(CLK_DIV - 1));
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      if (tick_o) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
      if (rise_o)      mdc_q <= 1'b1;
      else if (tick_o) mdc_q <= 1'b0;
    end
  end

  p_mdc_rise_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_q) |-> $past(rise_o));
  p_mdc_stop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !mdc_q);
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              in_frame_o,
  output logic [FIDX_W-1:0] frame_idx_o,
  output logic              done_o
);
  localparam int unsigned MAXL = (PRE_LEN > FRAME_W) ? PRE_LEN : FRAME_W;
  localparam int unsigned CW   = (MAXL > 1) ? $clog2(MAXL) : 1;

  phase_e        ph_q;
  logic [CW-1:0] cnt_q;
  logic          last_pre, last_frm;

  assign last_pre    = (ph_q == PH_PRE) && (cnt_q == CW'(PRE_LEN - 1));
  assign last_frm    = (ph_q == PH_FRM) && (cnt_q == CW'(FRAME_W - 1));
  assign busy_o      = (ph_q != PH_IDLE);
  assign in_frame_o  = (ph_q == PH_FRM);
  assign frame_idx_o = FIDX_W'(cnt_q);
  assign done_o      = tick_i && last_frm && !abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (abort_i) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q  <= PH_PRE;
          cnt_q <= '0;
        end
        PH_PRE: if (tick_i) begin
          if (last_pre) begin
            ph_q  <= PH_FRM;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_FRM: if (tick_i) begin
          if (last_frm) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  p_busy_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i && !abort_i) |=> busy_o);
  p_frame_after_pre_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_frame_o) |-> (frame_idx_o == '0));
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [FRAME_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              in_frame_i,
  input  logic [FIDX_W-1:0] frame_idx_i,
  input  logic              tick_i,
  input  logic              rise_i,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              is_read_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [DATA_W-1:0]  rd_q;
  logic               rd_op_q;
  logic               released, capture;

  assign released  = rd_op_q && in_frame_i && (frame_idx_i >= FIDX_W'(REL_IDX));
  assign capture   = busy_i && rise_i && rd_op_q && in_frame_i &&
                     (frame_idx_i >= FIDX_W'(DAT_IDX));
  assign mdio_o    = (busy_i && in_frame_i) ? sh_q[FRAME_W-1] : 1'b1;
  assign mdio_oe_o = busy_i && !released;
  assign is_read_o = rd_op_q;
  assign rd_data_o = rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      rd_q    <= '0;
      rd_op_q <= 1'b0;
    end else if (load_i) begin
      sh_q    <= wdata_i;
      rd_q    <= '0;
      rd_op_q <= (wdata_i[OP_HI:OP_LO] == OP_RD);
    end else begin
      if (busy_i && in_frame_i && tick_i) sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
      if (capture) rd_q <= {rd_q[DATA_W-2:0], mdio_i};
    end
  end

  // once released within a frame the line stays released to its end
  p_release_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !mdio_oe_o) |=> (!busy_i || !mdio_oe_o));
  p_no_release_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !rd_op_q) |-> mdio_oe_o);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned CLK_DIV = 48,
  parameter int unsigned PRE_LEN = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        port_en_i,
  input  logic        cmd_we_i,
  input  logic [31:0] cmd_wdata_i,
  output logic [31:0] cmd_o,
  output logic        idle_o,
  output logic        mdc_o,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  logic              busy, in_frame, done, rise, tick, run, accept, abort, is_read;
  logic [FIDX_W-1:0] frame_idx;
  logic [DATA_W-1:0] rd_data;
  logic [FRAME_W-1:0] cmd_q;

  assign accept = cmd_we_i && port_en_i && !busy;
  assign abort  = busy && !port_en_i;
  assign run    = busy && port_en_i;
  assign idle_o = !busy;
  assign cmd_o  = cmd_q;

  mdio_clk_div #(.CLK_DIV(CLK_DIV)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .rise_o(rise),
    .tick_o(tick),
    .mdc_o (mdc_o)
  );

  mdio_seq #(.PRE_LEN(PRE_LEN)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept),
    .abort_i    (abort),
    .tick_i     (tick),
    .busy_o     (busy),
    .in_frame_o (in_frame),
    .frame_idx_o(frame_idx),
    .done_o     (done)
  );

  mdio_shifter u_sh (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .wdata_i    (cmd_wdata_i),
    .busy_i     (busy),
    .in_frame_i (in_frame),
    .frame_idx_i(frame_idx),
    .tick_i     (tick),
    .rise_i     (rise),
    .mdio_i     (mdio_i),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o),
    .is_read_o  (is_read),
    .rd_data_o  (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cmd_q <= '0;
    else if (accept)            cmd_q <= cmd_wdata_i;
    else if (done && is_read)   cmd_q[DATA_W-1:0] <= rd_data;
  end

  p_accept_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && port_en_i && idle_o) |=> !idle_o);
  p_idle_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> (!mdc_o && !mdio_oe_o));
  p_cmd_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_o |=> (idle_o || $stable(cmd_o)));
  p_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_i |=> (idle_o && !mdc_o));
  p_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && port_en_i && idle_o) |=> (cmd_o == $past(cmd_wdata_i)));
endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
  localparam int DIV   = 48;
  localparam int PRE   = 32;
  localparam int FLEN  = (PRE + 32) * DIV;
  localparam int NVEC  = 5;
  // {command word, PHY data, PHY present}
  localparam logic [48:0] VEC [NVEC] = '{
    {32'h5282_1234, 16'h0000, 1'b1},
    {32'h6186_ABCD, 16'h796D, 1'b1},
    {32'h6FFE_0000, 16'h5A5A, 1'b0},
    {32'h507E_FFFF, 16'h0000, 1'b1},
    {32'h608A_0000, 16'h0001, 1'b1}
  };

  logic        clk = 0, rst_n = 0, en = 0, we = 0;
  logic [31:0] wdata = '0;
  logic [31:0] cmd;
  logic        idle, mdc, mdio_in, mdio_out, mdio_oe;

  int total = 0, bad = 0;
  int rc = 0, ndrv = 0;
  logic [63:0] seen = '0;
  logic [15:0] phy_data = '0;
  logic        phy_on = 0, phy_en = 0, phy_bit = 1;

  always #5 clk = ~clk;

  mdio_master #(.CLK_DIV(DIV), .PRE_LEN(PRE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .port_en_i(en), .cmd_we_i(we),
    .cmd_wdata_i(wdata), .cmd_o(cmd), .idle_o(idle), .mdc_o(mdc),
    .mdio_i(mdio_in), .mdio_o(mdio_out), .mdio_oe_o(mdio_oe)
  );

  assign mdio_in = mdio_oe ? mdio_out : (phy_en ? phy_bit : 1'b1);

  // PHY model: observes driven bits on rising MDC, drives read data after falling MDC
  always @(posedge mdc) begin
    rc = rc + 1;
    if (mdio_oe) begin
      seen = {seen[62:0], mdio_out};
      ndrv = ndrv + 1;
    end
  end
  always @(negedge mdc) begin
    int f;
    f = rc - PRE;
    if (phy_on && f >= 15 && f <= 31) begin
      phy_en  = 1'b1;
      phy_bit = (f == 15) ? 1'b0 : phy_data[31-f];
    end else begin
      phy_en = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic prep(input logic [15:0] d, input logic present);
    rc = 0; ndrv = 0; seen = '0; phy_en = 0;
    phy_data = d; phy_on = present;
  endtask

  task automatic strobe(input logic [31:0] w);
    @(negedge clk); we = 1; wdata = w;
    @(negedge clk); we = 0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (!idle && cyc < 2 * FLEN) begin
      @(negedge clk); cyc++;
    end
  endtask

  task automatic run_vec(input logic [31:0] c, input logic [15:0] d, input logic present);
    int cyc;
    bit rd;
    logic [63:0] exp_seen;
    logic [31:0] exp_cmd;
    rd = (c[29:28] == 2'b10);
    prep(d, present);
    strobe(c);
    chk(!idle, "R2 idle drop", {63'd0, idle}, 64'd0);
    chk(cmd == c, "R10 cmd load", {32'd0, cmd}, {32'd0, c});
    wait_idle(cyc);
    chk(cyc == FLEN, "R2 frame length", cyc, FLEN);
    if (rd) begin
      exp_seen = {17'd0, 32'hFFFF_FFFF, c[31:17]};
      exp_cmd  = {c[31:16], present ? d : 16'hFFFF};
      chk(ndrv == PRE + 15, "R6 driven count", ndrv, PRE + 15);
      chk(seen == exp_seen, "R4 R6 driven bits", seen, exp_seen);
      chk(cmd == exp_cmd, present ? "R6 read data" : "R7 absent PHY", {32'd0, cmd}, {32'd0, exp_cmd});
    end else begin
      exp_seen = {32'hFFFF_FFFF, c};
      chk(ndrv == PRE + 32, "R5 driven count", ndrv, PRE + 32);
      chk(seen == exp_seen, "R4 R5 driven bits", seen, exp_seen);
      chk(cmd == c, "R5 cmd kept", {32'd0, cmd}, {32'd0, c});
    end
    chk(!mdc && !mdio_oe, "R3 quiet after frame", {62'd0, mdc, mdio_oe}, 64'd0);
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc, hi, per;
    logic prev;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(idle && !mdc && !mdio_oe && cmd == 0, "R1 reset",
        {30'd0, idle, mdc, cmd}, {30'd0, 2'b10, 32'd0});
    rst_n = 1;
    @(negedge clk); en = 1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++)
      run_vec(VEC[i][48:17], VEC[i][16:1], VEC[i][0]);

    // R3 MDC shape during a frame
    prep(16'h0, 1'b1);
    strobe(32'h5000_0000);
    chk(!mdc, "R3 low first half", {63'd0, mdc}, 64'd0);
    prev = mdc;
    while (!(mdc && !prev)) begin prev = mdc; @(negedge clk); end
    hi = 0; per = 0; prev = mdc;
    while (!(mdc && !prev) || per == 0) begin
      prev = mdc;
      if (mdc) hi++;
      per++;
      @(negedge clk);
    end
    chk(per == DIV, "R3 mdc period", per, DIV);
    chk(hi == DIV / 2, "R3 mdc high time", hi, DIV / 2);
    wait_idle(cyc);

    // R8 write during a frame is ignored
    prep(16'h0, 1'b1);
    strobe(32'h5FFF_0F0F);
    repeat (100) @(negedge clk);
    strobe(32'h6000_0000);
    chk(cmd == 32'h5FFF_0F0F, "R8 cmd kept while busy", {32'd0, cmd}, 64'h5FFF_0F0F);
    wait_idle(cyc);
    chk(cyc + 102 == FLEN, "R8 frame length", cyc + 102, FLEN);
    chk(seen == {32'hFFFF_FFFF, 32'h5FFF_0F0F}, "R8 bits of first frame", seen, {32'hFFFF_FFFF, 32'h5FFF_0F0F});

    // R9 strobe while disabled
    @(negedge clk); en = 0;
    strobe(32'h6123_4567);
    chk(idle && cmd == 32'h5FFF_0F0F, "R9 ignored when disabled", {31'd0, idle, cmd}, {31'd0, 1'b1, 32'h5FFF_0F0F});
    @(negedge clk); en = 1;

    // R9 abort mid read
    prep(16'hBEEF, 1'b1);
    strobe(32'h6186_1111);
    repeat (PRE * DIV + 20 * DIV) @(negedge clk);
    en = 0;
    @(negedge clk);
    chk(idle && !mdc && !mdio_oe, "R9 abort quiet", {61'd0, idle, mdc, mdio_oe}, {61'd0, 3'b100});
    chk(cmd == 32'h6186_1111, "R9 cmd after abort", {32'd0, cmd}, 64'h6186_1111);
    repeat (3 * DIV) @(negedge clk);
    chk(!mdc && !mdio_oe, "R9 stays stopped", {62'd0, mdc, mdio_oe}, 64'd0);
    en = 1;
    @(negedge clk);
    run_vec(32'h6186_0000, 16'hC3A5, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule